// File: doc/BRIEF.md
# Codec Command-Port Register Bank

This block keeps the control register file on the receiving side of a frame-based audio link. Once per frame an upstream deserializer hands it the two 20-bit command slots, the frame-valid flag and the per-slot valid flags, and raises a one-cycle frame strobe. The block decodes the command and either updates one 16-bit register or captures a read result for the return path.

The bank holds sixty-four 16-bit registers on even byte addresses 00h to 7Eh. An odd address selects the even register just below it. Slot bits that carry no meaning are discarded, and so is any slot whose valid flag is clear. Register 00h returns a fixed identification word and cannot be written. Every stored value is brought out on a wide parallel bus for the codec's datapath. A read produces a one-cycle pulse with the even-aligned address and the data. An upstream serializer can place these in the next outgoing frame.

Top module: `cmdport_regbank`

## Requirements
- R1: After reset every register reads 0000h except register 00h, which reads ID_VALUE (default 16'h1819); rd_stb is 0 and rd_addr and rd_data are 0.
- R2: A write is a frame_stb cycle with frame_vld, slot1_vld and slot2_vld all 1 and slot1 bit 19 = 0. Register index slot1[18:13] then takes slot2[19:4]. The new value shows on regs_flat[16*idx +: 16] in the cycle after the strobe.
- R3: No register changes when frame_stb is 0, or when any of frame_vld, slot1_vld or slot2_vld is 0 on a write command.
- R4: slot1 bits 11:0 and slot2 bits 3:0 never affect any output.
- R5: Address bit slot1[12] is ignored. An odd address reads or writes the even register below it, and rd_addr always has bit 0 = 0.
- R6: A read is a frame_stb cycle with frame_vld and slot1_vld both 1 and slot1 bit 19 = 1. In the next cycle rd_stb is 1 for one cycle. At that point rd_addr = {slot1[18:13],0} and rd_data is that register's contents. slot2 and slot2_vld do not matter.
- R7: A read command with frame_vld or slot1_vld at 0 produces no rd_stb pulse.
- R8: Writes to register 00h (or 01h) are ignored, and it always reads ID_VALUE.
- R9: rd_addr and rd_data hold their last read result until the next read. A read on the strobe right after a write to the same register, even one cycle later, returns the newly written value.
- R10: A write changes only the register it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe: a frame's slots are present |
| frame_vld | input | 1 | Frame-valid tag flag |
| slot1_vld | input | 1 | Command address slot valid |
| slot2_vld | input | 1 | Command data slot valid |
| slot1 | input | 20 | Command address slot (bit 19 read=1/write=0, 18:12 address) |
| slot2 | input | 20 | Command data slot (bits 19:4 write data) |
| rd_stb | output | 1 | One-cycle pulse: read result valid |
| rd_addr | output | 7 | Even-aligned address of the last read |
| rd_data | output | 16 | Data of the last read |
| regs_flat | output | 1024 | All registers, register i on bits 16*i+15:16*i |

## Verification
Two functions can meet in one cycle. A read's registered result goes out at the same time as the storage takes the next command's write. The bench drives frame strobes on consecutive cycles: first a write and then a read of the same register, which must return the new word. It then drives a read followed at once by a write to that register, and the captured read data must stay at the old word while regs_flat shows the new one.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_WR   = 2'd1,
      CMD_RD   = 2'd2
   } cmd_kind_e;

endpackage

// File: rtl/cmdport_decode.sv
module cmdport_decode
   import cmdport_pkg::*;
#(
   parameter int SLOT_W = 20,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 7
) (
   input  logic                frame_stb,
   input  logic                frame_vld,
   input  logic                slot1_vld,
   input  logic                slot2_vld,
   input  logic [SLOT_W-1:0]   slot1,
   input  logic [SLOT_W-1:0]   slot2,
   output cmd_kind_e           kind,
   output logic [ADDR_W-2:0]   idx,
   output logic [DATA_W-1:0]   wdata
);
   localparam int RW_BIT  = SLOT_W - 1;
   localparam int ADR_TOP = SLOT_W - 2;
   localparam int ADR_LOW = SLOT_W - 1 - ADDR_W;
   localparam int DAT_LOW = SLOT_W - DATA_W;

   if (ADDR_W + 1 > SLOT_W) begin : g_bad_addr
      $error("cmdport_decode: address field does not fit in slot");
   end
   if (DATA_W > SLOT_W) begin : g_bad_data
      $error("cmdport_decode: data field wider than slot");
   end

   logic              cmd_ok;
   logic [ADDR_W-1:0] addr;

   assign cmd_ok = frame_stb & frame_vld & slot1_vld;
   assign addr   = slot1[ADR_TOP:ADR_LOW];
   assign idx    = addr[ADDR_W-1:1];
   assign wdata  = slot2[SLOT_W-1:DAT_LOW];

   always_comb begin
      kind = CMD_NONE;
      if (cmd_ok) begin
         if (slot1[RW_BIT])   kind = CMD_RD;
         else if (slot2_vld)  kind = CMD_WR;
      end
   end

   // Reserved and odd-address bits are discarded on purpose.
   logic unused_bits;
   if (ADR_LOW > 0 && DAT_LOW > 0) begin : g_both_pad
      assign unused_bits = ^{slot1[ADR_LOW-1:0], slot2[DAT_LOW-1:0], addr[0]};
   end else if (ADR_LOW > 0) begin : g_adr_pad
      assign unused_bits = ^{slot1[ADR_LOW-1:0], addr[0]};
   end else if (DAT_LOW > 0) begin : g_dat_pad
      assign unused_bits = ^{slot2[DAT_LOW-1:0], addr[0]};
   end else begin : g_no_pad
      assign unused_bits = addr[0];
   end

endmodule

// File: rtl/cmdport_store.sv
module cmdport_store
   import cmdport_pkg::*;
#(
   parameter int              DATA_W   = 16,
   parameter int              ADDR_W   = 7,
   parameter logic [DATA_W-1:0] ID_VALUE = 16'h1819,
   parameter bit              ID_LOCK  = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  cmd_kind_e                    kind,
   input  logic [ADDR_W-2:0]            idx,
   input  logic [DATA_W-1:0]            wdata,
   output logic [(2**(ADDR_W-1))*DATA_W-1:0] regs_flat
);
   localparam int NUM_REGS = 2 ** (ADDR_W - 1);

   logic wr_any;
   assign wr_any = (kind == CMD_WR);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (i == 0 && ID_LOCK) begin : g_id
         assign regs_flat[i*DATA_W +: DATA_W] = ID_VALUE;
      end else begin : g_rw
         localparam logic [DATA_W-1:0] RST_VAL = (i == 0) ? ID_VALUE : '0;
         logic [DATA_W-1:0] q;
         logic              we;
         assign we = wr_any && (idx == (ADDR_W-1)'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= RST_VAL;
            else if (we) q <= wdata;
         end
         assign regs_flat[i*DATA_W +: DATA_W] = q;
      end
   end

endmodule

// File: rtl/cmdport_readback.sv
module cmdport_readback
   import cmdport_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 7
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  cmd_kind_e                    kind,
   input  logic [ADDR_W-2:0]            idx,
   input  logic [(2**(ADDR_W-1))*DATA_W-1:0] regs_flat,
   output logic                         rd_stb,
   output logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data
);
   logic [DATA_W-1:0] sel_word;
   logic              rd_now;

   assign sel_word = regs_flat[idx*DATA_W +: DATA_W];
   assign rd_now   = (kind == CMD_RD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_stb  <= 1'b0;
         rd_addr <= '0;
         rd_data <= '0;
      end else begin
         rd_stb <= rd_now;
         if (rd_now) begin
            rd_addr <= {idx, 1'b0};
            rd_data <= sel_word;
         end
      end
   end

endmodule

// File: rtl/cmdport_regbank.sv
module cmdport_regbank
   import cmdport_pkg::*;
#(
   parameter int                SLOT_W   = 20,
   parameter int                DATA_W   = 16,
   parameter int                ADDR_W   = 7,
   parameter logic [DATA_W-1:0] ID_VALUE = 16'h1819,
   parameter bit                ID_LOCK  = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  frame_stb,
   input  logic                                  frame_vld,
   input  logic                                  slot1_vld,
   input  logic                                  slot2_vld,
   input  logic [SLOT_W-1:0]                     slot1,
   input  logic [SLOT_W-1:0]                     slot2,
   output logic                                  rd_stb,
   output logic [ADDR_W-1:0]                     rd_addr,
   output logic [DATA_W-1:0]                     rd_data,
   output logic [(2**(ADDR_W-1))*DATA_W-1:0]     regs_flat
);
   if (ADDR_W < 2) begin : g_bad_aw
      $error("cmdport_regbank: ADDR_W must be at least 2");
   end
   if (ID_LOCK && ID_VALUE == '0) begin : g_bad_id
      $error("cmdport_regbank: locked ID must be nonzero");
   end

   cmd_kind_e          kind;
   logic [ADDR_W-2:0]  idx;
   logic [DATA_W-1:0]  wdata;

   cmdport_decode #(.SLOT_W(SLOT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
      .frame_stb (frame_stb),
      .frame_vld (frame_vld),
      .slot1_vld (slot1_vld),
      .slot2_vld (slot2_vld),
      .slot1     (slot1),
      .slot2     (slot2),
      .kind      (kind),
      .idx       (idx),
      .wdata     (wdata)
   );

   cmdport_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
                   .ID_VALUE(ID_VALUE), .ID_LOCK(ID_LOCK)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind      (kind),
      .idx       (idx),
      .wdata     (wdata),
      .regs_flat (regs_flat)
   );

   cmdport_readback #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_readback (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind      (kind),
      .idx       (idx),
      .regs_flat (regs_flat),
      .rd_stb    (rd_stb),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data)
   );

endmodule

// File: rtl/cmdport_regbank_chk.sv
module cmdport_regbank_chk #(
   parameter int                SLOT_W   = 20,
   parameter int                DATA_W   = 16,
   parameter int                ADDR_W   = 7,
   parameter logic [DATA_W-1:0] ID_VALUE = 16'h1819,
   parameter bit                ID_LOCK  = 1'b1
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              frame_stb,
   input logic                              frame_vld,
   input logic                              slot1_vld,
   input logic                              slot2_vld,
   input logic [SLOT_W-1:0]                 slot1,
   input logic [SLOT_W-1:0]                 slot2,
   input logic                              rd_stb,
   input logic [ADDR_W-1:0]                 rd_addr,
   input logic [DATA_W-1:0]                 rd_data,
   input logic [(2**(ADDR_W-1))*DATA_W-1:0] regs_flat
);
   logic rd_cmd, wr_cmd;
   assign rd_cmd = frame_stb && frame_vld && slot1_vld && slot1[SLOT_W-1];
   assign wr_cmd = frame_stb && frame_vld && slot1_vld && slot2_vld && !slot1[SLOT_W-1];

   // R6
   rd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd |=> rd_stb);

   // R7
   rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |-> $past(rd_cmd));

   // R6
   rd_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd |=> rd_addr == {$past(slot1[SLOT_W-2 -: ADDR_W-1]), 1'b0});

   // R5
   rd_addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr[0] == 1'b0);

   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |-> ($stable(rd_data) && $stable(rd_addr)));

   // R3
   no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cmd |=> $stable(regs_flat));

   // R8
   id_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ID_LOCK -> (regs_flat[DATA_W-1:0] == ID_VALUE));

endmodule

bind cmdport_regbank cmdport_regbank_chk #(
   .SLOT_W(SLOT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .ID_VALUE(ID_VALUE), .ID_LOCK(ID_LOCK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame_vld(frame_vld),
   .slot1_vld(slot1_vld), .slot2_vld(slot2_vld), .slot1(slot1), .slot2(slot2),
   .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .regs_flat(regs_flat)
);

// File: tb/cmdport_regbank_bench.sv
`timescale 1ns/1ps
module cmdport_regbank_bench;
   localparam logic [15:0] ID = 16'h1819;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         frame_stb = 1'b0, frame_vld = 1'b0, slot1_vld = 1'b0, slot2_vld = 1'b0;
   logic [19:0]  slot1 = '0, slot2 = '0;
   logic         rd_stb;
   logic [6:0]   rd_addr;
   logic [15:0]  rd_data;
   logic [1023:0] regs_flat;

   int checks = 0;
   int errors = 0;
   logic [15:0] model [64];
   logic [6:0]  last_addr;
   logic [15:0] last_data;

   always #2 clk = ~clk;

   cmdport_regbank u_cmdport_regbank (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame_vld(frame_vld),
      .slot1_vld(slot1_vld), .slot2_vld(slot2_vld), .slot1(slot1), .slot2(slot2),
      .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .regs_flat(regs_flat)
   );

   // {fv, s1v, s2v, rw, addr[6:0], data[15:0], junk[3:0]}
   localparam logic [30:0] VEC [16] = '{
      {1'b1,1'b1,1'b1,1'b0,7'h02,16'h1234,4'hF},
      {1'b1,1'b1,1'b1,1'b0,7'h05,16'hABCD,4'h9},
      {1'b1,1'b1,1'b0,1'b1,7'h03,16'h7777,4'h3},
      {1'b1,1'b1,1'b1,1'b0,7'h7E,16'hFFFF,4'hF},
      {1'b1,1'b1,1'b1,1'b0,7'h7F,16'h0F0F,4'h1},
      {1'b1,1'b1,1'b1,1'b1,7'h7E,16'h0000,4'h0},
      {1'b0,1'b1,1'b1,1'b0,7'h10,16'h5555,4'h5},
      {1'b1,1'b0,1'b1,1'b0,7'h10,16'h5555,4'h5},
      {1'b1,1'b1,1'b0,1'b0,7'h10,16'h5555,4'h5},
      {1'b1,1'b1,1'b1,1'b1,7'h10,16'h2222,4'h2},
      {1'b0,1'b1,1'b1,1'b1,7'h10,16'h0000,4'h0},
      {1'b1,1'b1,1'b1,1'b0,7'h00,16'hDEAD,4'hE},
      {1'b1,1'b1,1'b1,1'b1,7'h01,16'h0000,4'h0},
      {1'b1,1'b1,1'b1,1'b0,7'h40,16'h8001,4'h7},
      {1'b1,1'b1,1'b1,1'b1,7'h41,16'hBEEF,4'hC},
      {1'b1,1'b0,1'b1,1'b1,7'h05,16'h0000,4'h0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_file(input string req);
      int bad = -1;
      for (int i = 0; i < 64; i++)
         if (regs_flat[i*16 +: 16] !== model[i] && bad < 0) bad = i;
      checks++;
      if (bad >= 0) begin
         errors++;
         $display("FAIL %s reg %0d actual=%h expected=%h", req, bad,
                  regs_flat[bad*16 +: 16], model[bad]);
      end
   endtask

   // Drive one frame on a falling edge; optionally drop the strobe afterwards.
   task automatic drive(input logic [30:0] v, input bit stb);
      frame_vld = v[30]; slot1_vld = v[29]; slot2_vld = v[28];
      slot1 = {v[27], v[26:20], 12'hA5A};
      slot2 = {v[19:4], v[3:0]};
      frame_stb = stb;
   endtask

   // Reference behaviour taken from the requirements.
   task automatic apply_model(input logic [30:0] v, output bit is_rd);
      logic [5:0] ix;
      ix = v[26:21];
      is_rd = 1'b0;
      if (v[30] && v[29]) begin
         if (v[27]) begin
            is_rd = 1'b1;
            last_addr = {ix, 1'b0};
            last_data = model[ix];
         end else if (v[28] && ix != 0) begin
            model[ix] = v[19:4];
         end
      end
   endtask

   initial begin
      #(200000 * 4);
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit is_rd;
      logic [30:0] v;
      for (int i = 0; i < 64; i++) model[i] = 16'h0000;
      model[0] = ID;
      last_addr = '0; last_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_file("R1 reset regfile");
      check("R1 reset rd_stb", {31'd0, rd_stb}, 32'd0);
      check("R1 reset rd_data", {16'd0, rd_data}, 32'd0);

      // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
      for (int n = 0; n < 16; n++) begin
         v = VEC[n];
         drive(v, 1'b1);
         apply_model(v, is_rd);
         @(negedge clk);
         frame_stb = 1'b0;
         check("R6/R7 rd_stb", {31'd0, rd_stb}, {31'd0, is_rd});
         check("R5/R6/R9 rd_addr", {25'd0, rd_addr}, {25'd0, last_addr});
         check("R4/R6/R8/R9 rd_data", {16'd0, rd_data}, {16'd0, last_data});
         check_file("R2/R3/R4/R5/R8/R10 regfile");
      end

      // R3: fully valid write with no strobe is ignored
      drive({1'b1,1'b1,1'b1,1'b0,7'h20,16'h6666,4'h0}, 1'b0);
      @(negedge clk);
      @(negedge clk);
      check_file("R3 no strobe");

      // R9: write then read on back-to-back strobes
      drive({1'b1,1'b1,1'b1,1'b0,7'h22,16'hC0DE,4'h0}, 1'b1);
      model[17] = 16'hC0DE;
      @(negedge clk);
      drive({1'b1,1'b1,1'b0,1'b1,7'h22,16'h0000,4'h0}, 1'b1);
      @(negedge clk);
      frame_stb = 1'b0;
      check("R9 read after write data", {16'd0, rd_data}, 32'h0000C0DE);
      check("R9 read after write stb", {31'd0, rd_stb}, 32'd1);

      // R9: read then write on back-to-back strobes; read result holds
      drive({1'b1,1'b1,1'b0,1'b1,7'h22,16'h0000,4'h0}, 1'b1);
      @(negedge clk);
      drive({1'b1,1'b1,1'b1,1'b0,7'h22,16'h1111,4'h0}, 1'b1);
      model[17] = 16'h1111;
      @(negedge clk);
      frame_stb = 1'b0;
      check("R9 read held across write", {16'd0, rd_data}, 32'h0000C0DE);
      check("R9 stb ended", {31'd0, rd_stb}, 32'd0);
      check_file("R2/R10 write after read");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule